// File: doc/BRIEF.md
# Configuration Revision Select Sequencer

This block sits in front of a configuration memory that holds up to four design images ("revisions"), each stored as a run of whole fixed-size blocks. It decides which revision to load, looks up where that revision lives, and then produces the read addresses for it one word at a time. The revision number can come from two external select pins or from two internal control bits, and an enable input picks the source.

The selection is captured twice: during power-up reset, and again whenever a configuration request pulse rises while chip enable is held low. Each capture restarts the address walk at the start of the selected revision. A small table, written through a simple register port, gives the first block and the number of blocks of each revision. The walk covers every word of every block of the revision, including the ones-padded tail of the last block, and then raises a done flag. A revision that cannot be served raises an error flag instead.

Top module: `rev_select_seq`

## Requirements
- R1: Revision numbers are two bits (0 = 00, 1 = 01, 2 = 10, 3 = 11). With `ext_sel_en` low the pins `rev_pins` choose the revision; with it high the bits `rev_bits` choose it. The captured number is shown on `rev_active`.
- R2: While `rst_n` is low the selected source is captured on every clock; the value present at the last reset clock is the one in force after release, and one clock after release the walk is (re)started for it.
- R3: After reset, a rising edge of `cfg_pulse` seen on a clock while `ce_n` is low captures the selection on that clock (`rev_active` updates after it) and restarts the walk one clock later; changes on the select inputs at any other time leave `rev_active` unchanged.
- R4: A rising edge of `cfg_pulse` while `ce_n` is high is ignored: `rev_active`, `rd_addr`, `rd_valid`, `done` and `err` keep their values.
- R5: On a successful restart, `rd_valid` goes high and `rd_addr` equals the revision's start block multiplied by the block size (2^BLK_AW words; 16 by default).
- R6: While `rd_valid` is high, each clock with `adv` high moves `rd_addr` up by one word; with `adv` low the address holds.
- R7: After the final word of the revision's last block has been advanced past (block count × block size advances in total), `rd_valid` drops and `done` rises and stays high until the next restart.
- R8: Restarting on a revision whose block count is zero sets `err`, keeps `rd_valid` low and produces no addresses.
- R9: Restarting on a revision whose start block plus block count exceeds the number of memory blocks, or whose number is not below min(4, NUM_BLOCKS), also sets `err` with `rd_valid` low.
- R10: Every restart clears `done` and `err` before the new outcome is shown.
- R11: The table is written on a clock with `tbl_we` high at slot `tbl_idx` with `tbl_start_blk` and `tbl_blk_cnt`; reset clears all block counts to zero, so the walk started right after reset reports `err` until the table is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| ext_sel_en | input | 1 | Source select: 0 = external pins, 1 = internal bits |
| rev_pins | input | 2 | External revision select pins |
| rev_bits | input | 2 | Internal programmable revision bits |
| ce_n | input | 1 | Chip enable, active low |
| cfg_pulse | input | 1 | Configuration request; rising edge triggers a new capture |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 2 | Table slot (revision number) to write |
| tbl_start_blk | input | BIW | First block of the revision |
| tbl_blk_cnt | input | CW | Number of blocks of the revision |
| adv | input | 1 | Advance to the next word |
| rd_addr | output | AW | Current word address |
| rd_valid | output | 1 | `rd_addr` is a live address of the revision |
| rev_active | output | 2 | Revision captured at the last sampling event |
| done | output | 1 | Whole revision has been walked |
| err | output | 1 | Selected revision cannot be served |

## Verification
A wrong captured revision shows on `rev_active` one clock after the sampling event and on `rd_addr` one clock later, as a start address from another table slot. A wrong last-address or block-count value shows only at the end of a walk, as `done` arriving early or late by whole words, so every directed walk runs to completion and the boundary case of the last block of memory is walked to its top address. A missed edge or a spurious capture with chip enable high shows as a restart that resets the address and clears `done` when it should not, observed on the clock after the pulse.

// File: rtl/rev_seq_pkg.sv
// Shared definitions for the revision select sequencer.
// Assumes at most four revision slots, encoded on two bits.
package rev_seq_pkg;
    typedef logic [1:0] rev_id_t;
    localparam int REV_SLOTS = 4;

    // Number of revisions a memory of n blocks can hold.
    function automatic int max_revs(input int n);
        return (n < REV_SLOTS) ? n : REV_SLOTS;
    endfunction
endpackage

// File: rtl/rev_src_latch.sv
// Revision source mux and capture.
// Picks pins or internal bits, captures the choice on every reset clock and
// on a cfg_pulse rising edge with ce_n low, and pulses restart_o one clock
// after each capture (including the first clock after reset release).
// Assumes cfg_pulse and ce_n are already synchronous to clk.
module rev_src_latch
    import rev_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ext_sel_en,
    input  rev_id_t rev_pins,
    input  rev_id_t rev_bits,
    input  logic    ce_n,
    input  logic    cfg_pulse,
    output rev_id_t rev_q,
    output logic    restart_o
);
    rev_id_t sel_rev;
    logic    cfg_d;
    logic    cfg_rise;

    // Source mux: internal bits when enabled, else external pins.
    always_comb begin
        sel_rev  = ext_sel_en ? rev_bits : rev_pins;
        cfg_rise = cfg_pulse & ~cfg_d & ~ce_n;
    end

    // Capture register, edge history and restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_q     <= sel_rev;
            cfg_d     <= cfg_pulse;
            restart_o <= 1'b1;
        end else begin
            cfg_d     <= cfg_pulse;
            restart_o <= cfg_rise;
            if (cfg_rise) begin
                rev_q <= sel_rev;
            end
        end
    end

    // R4
    ce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !restart_o);

    // R3
    rev_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rev_q) |-> restart_o);
endmodule

// File: rtl/rev_table.sv
// Revision table: start block and block count per revision slot.
// Slots at or above min(4, NUM_BLOCKS) are not built and read as empty.
// Lookup is combinational and reports whether the entry can be served.
module rev_table
    import rev_seq_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int BIW        = 3,
    parameter int CW         = 4,
    parameter int SW         = CW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  rev_id_t        wr_idx,
    input  logic [BIW-1:0] wr_start,
    input  logic [CW-1:0]  wr_cnt,
    input  rev_id_t        rd_idx,
    output logic [BIW-1:0] rd_start,
    output logic [SW-1:0]  rd_end,
    output logic           rd_ok
);
    localparam int MAXR = max_revs(NUM_BLOCKS);

    logic [REV_SLOTS*BIW-1:0] st_flat;
    logic [REV_SLOTS*CW-1:0]  ct_flat;
    logic [CW-1:0]            rd_cnt;

    for (genvar g = 0; g < REV_SLOTS; g++) begin : g_slot
        if (g < MAXR) begin : g_live
            logic [BIW-1:0] st_r;
            logic [CW-1:0]  ct_r;
            // Slot storage: cleared by reset, loaded by a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_r <= '0;
                    ct_r <= '0;
                end else if (wr_en && wr_idx == rev_id_t'(g)) begin
                    st_r <= wr_start;
                    ct_r <= wr_cnt;
                end
            end
            assign st_flat[g*BIW +: BIW] = st_r;
            assign ct_flat[g*CW +: CW]   = ct_r;
        end else begin : g_absent
            assign st_flat[g*BIW +: BIW] = '0;
            assign ct_flat[g*CW +: CW]   = '0;
        end
    end

    // Lookup and range check of the selected slot.
    always_comb begin
        rd_start = st_flat[rd_idx*BIW +: BIW];
        rd_cnt   = ct_flat[rd_idx*CW +: CW];
        rd_end   = SW'(rd_start) + SW'(rd_cnt);
        rd_ok    = (rd_cnt != '0) && (rd_end <= SW'(NUM_BLOCKS))
                   && (32'(rd_idx) < MAXR);
    end

    // R11
    tbl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && 32'(wr_idx) < MAXR) |=>
            (st_flat[$past(wr_idx)*BIW +: BIW] == $past(wr_start))
            && (ct_flat[$past(wr_idx)*CW +: CW] == $past(wr_cnt)));
endmodule

// File: rtl/rev_addr_walker.sv
// Address walker: on restart loads the revision's first word address and
// last word address, then steps one word per clock with adv high, and
// raises done after the last word. A bad entry raises err instead.
// Assumes restart is a single-clock pulse and the lookup is valid with it.
module rev_addr_walker #(
    parameter int BLK_AW = 4,
    parameter int BIW    = 3,
    parameter int SW     = 5,
    parameter int AW     = BIW + BLK_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic [BIW-1:0] lk_start,
    input  logic [SW-1:0]  lk_end,
    input  logic           lk_ok,
    input  logic           adv,
    output logic [AW-1:0]  addr,
    output logic           active,
    output logic           done,
    output logic           err
);
    localparam int EW = SW + BLK_AW;

    logic [AW-1:0] start_addr;
    logic [EW-1:0] end_w;
    logic [EW-1:0] last_w;
    logic [AW-1:0] last_q;

    // Block index to word address conversion for first and last word.
    always_comb begin
        start_addr = {lk_start, {BLK_AW{1'b0}}};
        end_w      = {lk_end, {BLK_AW{1'b0}}};
        last_w     = end_w - EW'(1);
    end

    // Walk state: load on restart, step on adv, finish at last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            last_q <= '0;
            active <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else if (restart) begin
            done <= 1'b0;
            if (lk_ok) begin
                addr   <= start_addr;
                last_q <= last_w[AW-1:0];
                active <= 1'b1;
                err    <= 1'b0;
            end else begin
                active <= 1'b0;
                err    <= 1'b1;
            end
        end else if (active && adv) begin
            if (addr == last_q) begin
                active <= 1'b0;
                done   <= 1'b1;
            end else begin
                addr <= addr + AW'(1);
            end
        end
    end

    // R8
    bad_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !lk_ok) |=> (err && !active && !done));

    // R5
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && lk_ok) |=> (active && !err && addr[BLK_AW-1:0] == '0));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !adv && !restart) |=> ($stable(addr) && active));

    // R7
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!active && !err));
endmodule

// File: rtl/rev_select_seq.sv
// Top: revision select sequencer. Captures the revision number, looks it up
// in the revision table and walks the revision's word addresses.
// Assumes all inputs are synchronous to clk; memory and decompression
// are outside this block.
module rev_select_seq #(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_AW     = 4,
    parameter int BIW        = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    parameter int CW         = $clog2(NUM_BLOCKS + 1),
    parameter int AW         = BIW + BLK_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ext_sel_en,
    input  logic [1:0]     rev_pins,
    input  logic [1:0]     rev_bits,
    input  logic           ce_n,
    input  logic           cfg_pulse,
    input  logic           tbl_we,
    input  logic [1:0]     tbl_idx,
    input  logic [BIW-1:0] tbl_start_blk,
    input  logic [CW-1:0]  tbl_blk_cnt,
    input  logic           adv,
    output logic [AW-1:0]  rd_addr,
    output logic           rd_valid,
    output logic [1:0]     rev_active,
    output logic           done,
    output logic           err
);
    localparam int SW = CW + 1;

    logic [1:0]     rev_q;
    logic           restart;
    logic [BIW-1:0] lk_start;
    logic [SW-1:0]  lk_end;
    logic           lk_ok;

    rev_src_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sel_en(ext_sel_en),
        .rev_pins  (rev_pins),
        .rev_bits  (rev_bits),
        .ce_n      (ce_n),
        .cfg_pulse (cfg_pulse),
        .rev_q     (rev_q),
        .restart_o (restart)
    );

    rev_table #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BIW       (BIW),
        .CW        (CW),
        .SW        (SW)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_start(tbl_start_blk),
        .wr_cnt  (tbl_blk_cnt),
        .rd_idx  (rev_q),
        .rd_start(lk_start),
        .rd_end  (lk_end),
        .rd_ok   (lk_ok)
    );

    rev_addr_walker #(
        .BLK_AW(BLK_AW),
        .BIW   (BIW),
        .SW    (SW),
        .AW    (AW)
    ) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .lk_start(lk_start),
        .lk_end  (lk_end),
        .lk_ok   (lk_ok),
        .adv     (adv),
        .addr    (rd_addr),
        .active  (rd_valid),
        .done    (done),
        .err     (err)
    );

    assign rev_active = rev_q;

    // R10
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done);
endmodule

// File: tb/rev_select_seq_tb.sv
module rev_select_seq_tb;
    localparam int NB  = 8;
    localparam int BLK = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_sel_en = 1'b0;
    logic [1:0] rev_pins = 2'b10;
    logic [1:0] rev_bits = 2'b00;
    logic       ce_n = 1'b0;
    logic       cfg_pulse = 1'b0;
    logic       tbl_we = 1'b0;
    logic [1:0] tbl_idx = 2'b00;
    logic [2:0] tbl_start_blk = '0;
    logic [3:0] tbl_blk_cnt = '0;
    logic       adv = 1'b0;
    logic [6:0] rd_addr;
    logic       rd_valid;
    logic [1:0] rev_active;
    logic       done;
    logic       err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model
    int  t_start [4];
    int  t_cnt   [4];
    int  m_addr, m_last;
    bit  m_valid, m_done, m_err;
    int  m_rev;

    always #2.5 clk = ~clk;

    rev_select_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ext_sel_en(ext_sel_en),
        .rev_pins(rev_pins), .rev_bits(rev_bits), .ce_n(ce_n),
        .cfg_pulse(cfg_pulse), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_start_blk(tbl_start_blk), .tbl_blk_cnt(tbl_blk_cnt),
        .adv(adv), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rev_active(rev_active), .done(done), .err(err)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit entry_ok(input int r);
        return (t_cnt[r] != 0) && (t_start[r] + t_cnt[r] <= NB);
    endfunction

    task automatic model_restart(input int r);
        m_done = 0;
        if (entry_ok(r)) begin
            m_addr = t_start[r] * BLK;
            m_last = (t_start[r] + t_cnt[r]) * BLK - 1;
            m_valid = 1; m_err = 0;
        end else begin
            m_valid = 0; m_err = 1;
        end
    endtask

    task automatic compare(input string req);
        check(req, "rd_valid", int'(rd_valid), int'(m_valid));
        check(req, "done", int'(done), int'(m_done));
        check(req, "err", int'(err), int'(m_err));
        check(req, "rev_active", int'(rev_active), m_rev);
        if (m_valid) check(req, "rd_addr", int'(rd_addr), m_addr);
    endtask

    // one clock with adv = a; model advances; outputs checked after edge
    task automatic tick(input bit a, input string req);
        adv = a;
        @(posedge clk);
        if (a && m_valid) begin
            if (m_addr == m_last) begin m_valid = 0; m_done = 1; end
            else m_addr++;
        end
        #1;
        compare(req);
    endtask

    task automatic wr_tbl(input int r, input int s, input int c);
        tbl_we = 1; tbl_idx = 2'(r); tbl_start_blk = 3'(s); tbl_blk_cnt = 4'(c);
        tick(0, "R11");
        tbl_we = 0;
        t_start[r] = s; t_cnt[r] = c;
    endtask

    // rising cfg_pulse with ce_n low: capture, then restart one clock later
    task automatic cfg_event(input string req);
        m_rev = ext_sel_en ? int'(rev_bits) : int'(rev_pins);
        adv = 0; cfg_pulse = 1;
        @(posedge clk); #1;
        check("R3", "rev_active after edge", int'(rev_active), m_rev);
        cfg_pulse = 0;
        @(posedge clk);
        model_restart(m_rev);
        #1;
        compare(req);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h2f1d);
        for (int i = 0; i < 4; i++) begin t_start[i] = 0; t_cnt[i] = 0; end
        m_valid = 0; m_done = 0; m_err = 0; m_addr = 0; m_last = 0;

        // reset with pins = 10 selected
        repeat (3) @(posedge clk);
        #1;
        m_rev = 2;
        check("R11", "rd_valid in reset", int'(rd_valid), 0);
        check("R11", "err in reset", int'(err), 0);
        rst_n = 1;
        @(posedge clk);
        model_restart(2);
        #1;
        compare("R2");
        check("R11", "err with empty table", int'(err), 1);

        // pins change without event: no effect
        rev_pins = 2'b01;
        tick(0, "R3");
        tick(0, "R3");

        // load table
        wr_tbl(0, 0, 1);
        wr_tbl(1, 1, 2);
        wr_tbl(2, 3, 0);
        wr_tbl(3, 6, 3);

        // internal bits select revision 1
        ext_sel_en = 1; rev_bits = 2'b01; rev_pins = 2'b11;
        cfg_event("R1");
        check("R5", "start address rev1", int'(rd_addr), 16);
        check("R10", "err cleared", int'(err), 0);
        repeat (3) tick(0, "R6");
        for (int k = 0; k < 2 * BLK; k++) tick(1, "R6");
        check("R7", "done after 32 words", int'(done), 1);
        check("R7", "valid low at end", int'(rd_valid), 0);
        tick(1, "R7");

        // edge while ce_n high is ignored
        ce_n = 1; rev_bits = 2'b00;
        cfg_pulse = 1; tick(0, "R4");
        cfg_pulse = 0; tick(0, "R4");
        tick(0, "R4");
        check("R4", "rev_active kept", int'(rev_active), 1);
        check("R4", "done kept", int'(done), 1);
        ce_n = 0;

        // external pins select revision 0
        ext_sel_en = 0; rev_pins = 2'b00;
        cfg_event("R10");
        check("R1", "pins source rev0", int'(rev_active), 0);
        check("R10", "done cleared", int'(done), 0);
        for (int k = 0; k < BLK; k++) tick(1, "R7");

        // zero block count
        rev_pins = 2'b10;
        cfg_event("R8");
        check("R8", "err zero count", int'(err), 1);
        tick(1, "R8");

        // overrun past memory end
        rev_pins = 2'b11;
        cfg_event("R9");
        check("R9", "err overrun", int'(err), 1);

        // last block of memory, walk to top address
        wr_tbl(3, 7, 1);
        cfg_event("R11");
        for (int k = 0; k < BLK - 1; k++) tick(1, "R6");
        check("R7", "top address", int'(rd_addr), NB * BLK - 1);
        tick(1, "R7");
        check("R7", "done at top", int'(done), 1);

        // constrained random
        for (int it = 0; it < 40; it++) begin
            if ($urandom % 2 == 0) begin
                int r, s, c;
                r = $urandom % 4;
                s = $urandom % NB;
                c = ($urandom % 6 == 0) ? 0 : 1 + ($urandom % (NB - s));
                wr_tbl(r, s, c);
            end
            ext_sel_en = 1'($urandom);
            rev_pins = 2'($urandom);
            rev_bits = 2'($urandom);
            cfg_event("R5");
            for (int k = 0; k < 60; k++) tick(($urandom % 4) != 0, "R6");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule